// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word-select clock and a data line. The bit and word clocks are inputs from an external source. They are passed through a synchroniser and sampled with a faster system clock. The block looks only at rising edges of the bit clock. A 3-bit format code picks how each half-frame is laid out. The choices are right-aligned words of 16, 20 or 24 bits, left-aligned words, or the I2S layout, in which the word starts one bit late.

Each completed channel word becomes a 24-bit two's-complement sample. Once the right word of a frame ends, the left and right samples of that frame appear together with a single-cycle valid pulse. The format code is loaded only while the active-low power-down input is held low. The value present when power-down is released stays in force until the next power-down.

Top module: `audio_serial_rx`

## Requirements
- R1: Data is taken MSB first, one bit on each rising bit-clock edge. With format code 0, the last 16 bits before a word-select change form the word. It is sign-extended to 24 bits, and the earlier bits of that half-frame are ignored.
- R2: With format code 1, the last 20 bits before a word-select change form the word, sign-extended to 24 bits.
- R3: With format code 4, the last 24 bits before a word-select change form the word.
- R4: With format code 2, the word starts at the first bit after a word-select change. The first 24 bits are kept. A half-frame shorter than 24 bits gives its bits in the top positions and zeros below them.
- R5: With format code 3, the word MSB is the second bit after a word-select change (one bit of delay). A low word-select marks the left channel, and alignment and padding follow R4.
- R6: Format codes 5 and 6 decode exactly like codes 2 and 3.
- R7: In formats 0, 1, 2, 4 and 5, a high word-select marks the left channel.
- R8: `valid_o` rises for one system-clock cycle after each right word that is preceded by a complete left word, and `left_o`/`right_o` then hold that frame's pair. The outputs change only together with that pulse. A half-frame that did not start at a word-select change yields nothing.
- R9: Format code 7 is reserved and produces no valid pulses.
- R10: `fmt_code` is loaded while `pdn_n` is low and held while `pdn_n` is high. Changes made while `pdn_n` is high have no effect.
- R11: While `pdn_n` is low, no valid pulses occur, and framing restarts from scratch after release.
- R12: After reset, `valid_o` is low and both sample outputs are zero.
- R13: Half-frames of 16, 20, 24 and 32 bit clocks (32, 40, 48 and 64 times the frame rate) are decoded for every format that the half-frame length can carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down; the format loads while low |
| fmt_code | input | 3 | Serial format selection |
| bclk_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word-select (channel) clock |
| sd_in | input | 1 | Serial data |
| left_o | output | SAMPLE_W (24) | Left sample, two's complement |
| right_o | output | SAMPLE_W (24) | Right sample, two's complement |
| valid_o | output | 1 | One-cycle pulse when a new pair is present |

## Verification
The bench builds the block with its default parameters: 24-bit samples, a 32-bit maximum half-frame and two synchroniser stages. The bit clock runs at six system clocks per bit. With these values it can sweep every format code against every half-frame length the format allows, from 16 to 32 bits. That covers the zero-padding of short left-aligned words, the I2S word whose last bit crosses the word-select change, and the sign extension of right-aligned words that have filler bits in front of them. Expected pairs are computed arithmetically from the value placed on the wire.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

   typedef enum logic [2:0] {
      FMT_RJ16    = 3'd0,
      FMT_RJ20    = 3'd1,
      FMT_LJ      = 3'd2,
      FMT_I2S     = 3'd3,
      FMT_RJ24    = 3'd4,
      FMT_LJ_ALT  = 3'd5,
      FMT_I2S_ALT = 3'd6,
      FMT_NONE    = 3'd7
   } fmt_e;

   // Decoded framing controls for the deserialiser
   typedef struct packed {
      logic       enable;     // format is usable
      logic       delay1;     // word starts one bit after word-select change
      logic       right_just; // keep the bits just before the change
      logic [5:0] rj_bits;    // word length for right-aligned formats
   } frame_cfg_t;

   function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
      frame_cfg_t c;
      c = '{enable: 1'b1, delay1: 1'b0, right_just: 1'b0, rj_bits: 6'd24};
      case (fmt_e'(code))
         FMT_RJ16:    begin c.right_just = 1'b1; c.rj_bits = 6'd16; end
         FMT_RJ20:    begin c.right_just = 1'b1; c.rj_bits = 6'd20; end
         FMT_RJ24:    begin c.right_just = 1'b1; c.rj_bits = 6'd24; end
         FMT_LJ,
         FMT_LJ_ALT:  c.delay1 = 1'b0;
         FMT_I2S,
         FMT_I2S_ALT: c.delay1 = 1'b1;
         default:     c.enable = 1'b0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/asrx_sync_edge.sv
module asrx_sync_edge #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             rise0
);
   initial assert (STAGES >= 2 && WIDTH >= 1)
      else $fatal(1, "asrx_sync_edge: bad parameters");

   logic [WIDTH-1:0] stg [STAGES];
   logic             last0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         last0 <= 1'b0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         last0 <= stg[STAGES-1][0];
      end
   end

   assign dout  = stg[STAGES-1];
   assign rise0 = stg[STAGES-1][0] & ~last0;

endmodule

// File: rtl/asrx_cfg_hold.sv
module asrx_cfg_hold
   import asrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pdn_n,
   input  logic [2:0] code,
   output frame_cfg_t cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= decode_fmt(3'd7);
      else if (!pdn_n) cfg <= decode_fmt(code);
   end

   // R10: configuration frozen while power-down is released
   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_n && $past(pdn_n)) |-> $stable(cfg));

endmodule

// File: rtl/asrx_deser.sv
module asrx_deser
   import asrx_pkg::*;
#(
   parameter int W        = 24,
   parameter int MAX_HALF = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  frame_cfg_t   cfg,
   input  logic         bit_stb,
   input  logic         ws,
   input  logic         sd,
   output logic         word_stb,
   output logic [W-1:0] word,
   output logic         word_left
);
   localparam int             CW      = $clog2(MAX_HALF + 1);
   localparam logic [CW-1:0]  CNT_MAX = CW'(MAX_HALF);

   initial assert (MAX_HALF >= W && W >= 24)
      else $fatal(1, "asrx_deser: MAX_HALF must cover W, W at least 24");

   logic [MAX_HALF-1:0] sr;
   logic [CW-1:0]       cnt;
   logic                ws_last, have_ws, eff_prev, have_eff, started;
   logic                eff, eff_ok, edge_now, idle;

   logic [MAX_HALF+W-1:0] lj_ext;
   logic [W-1:0]          lj_word, rj_al, rj_word, pick;
   int                    sh_l, sh_r;

   always_comb begin
      idle     = !run || !cfg.enable;
      eff      = cfg.delay1 ? ws_last : ws;
      eff_ok   = cfg.delay1 ? have_ws : 1'b1;
      edge_now = bit_stb && eff_ok && have_eff && (eff != eff_prev);
   end

   // Word extraction: left-aligned keeps the first W bits of the half,
   // right-aligned keeps the last rj_bits bits, sign-extended.
   always_comb begin
      sh_l    = MAX_HALF - int'(cnt);
      lj_ext  = {sr, {W{1'b0}}} << sh_l;
      lj_word = lj_ext[MAX_HALF+W-1 -: W];
      sh_r    = W - int'(cfg.rj_bits);
      rj_al   = sr[W-1:0] << sh_r;
      rj_word = $signed(rj_al) >>> sh_r;
      pick    = cfg.right_just ? rj_word : lj_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0; cnt <= '0; ws_last <= 1'b0; have_ws <= 1'b0;
         eff_prev <= 1'b0; have_eff <= 1'b0; started <= 1'b0;
         word_stb <= 1'b0; word <= '0; word_left <= 1'b0;
      end else if (idle) begin
         sr <= '0; cnt <= '0; ws_last <= 1'b0; have_ws <= 1'b0;
         eff_prev <= 1'b0; have_eff <= 1'b0; started <= 1'b0;
         word_stb <= 1'b0;
      end else begin
         word_stb <= 1'b0;
         if (bit_stb) begin
            ws_last <= ws;
            have_ws <= 1'b1;
            if (eff_ok) begin
               eff_prev <= eff;
               have_eff <= 1'b1;
               if (edge_now) begin
                  sr      <= {{(MAX_HALF-1){1'b0}}, sd};
                  cnt     <= CW'(1);
                  started <= 1'b1;
                  if (started) begin
                     word_stb  <= 1'b1;
                     word      <= pick;
                     word_left <= cfg.delay1 ? !eff_prev : eff_prev;
                  end
               end else begin
                  sr <= {sr[MAX_HALF-2:0], sd};
                  if (cnt != CNT_MAX) cnt <= cnt + CW'(1);
               end
            end
         end
      end
   end

   // R1: a word completes only on a sampled rising bit-clock edge
   p_stb_on_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> $past(bit_stb));
   // R9: reserved format never completes a word
   p_rsvd_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.enable |=> !word_stb);
   // R13: bit count stays within the supported half-frame
   p_cnt_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import asrx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int MAX_HALF    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pdn_n,
   input  logic [2:0]          fmt_code,
   input  logic                bclk_in,
   input  logic                ws_in,
   input  logic                sd_in,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   frame_cfg_t          cfg;
   logic [2:0]          pins_s;
   logic                bit_stb, word_stb, word_left, left_ok;
   logic [SAMPLE_W-1:0] word, left_hold;

   asrx_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din({sd_in, ws_in, bclk_in}),
      .dout(pins_s), .rise0(bit_stb));

   asrx_cfg_hold i_cfg (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .code(fmt_code), .cfg(cfg));

   asrx_deser #(.W(SAMPLE_W), .MAX_HALF(MAX_HALF)) i_deser (
      .clk(clk), .rst_n(rst_n), .run(pdn_n), .cfg(cfg),
      .bit_stb(bit_stb), .ws(pins_s[1]), .sd(pins_s[2]),
      .word_stb(word_stb), .word(word), .word_left(word_left));

   // Pairing of left and right words into frames
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold <= '0; left_ok <= 1'b0;
         left_o <= '0; right_o <= '0; valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (!pdn_n || !cfg.enable) begin
            left_ok <= 1'b0;
         end else if (word_stb) begin
            if (word_left) begin
               left_hold <= word;
               left_ok   <= 1'b1;
            end else begin
               if (left_ok) begin
                  left_o  <= left_hold;
                  right_o <= word;
                  valid_o <= 1'b1;
               end
               left_ok <= 1'b0;
            end
         end
      end
   end

   // R11: no pulse while powered down
   p_pd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n |=> !valid_o);
   // R8: pulse lasts a single cycle
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R8: samples move only with the pulse
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
   localparam int CLK_P    = 10;
   localparam int BIT_HALF = 3;
   localparam int LIMIT    = 190000;

   logic        clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b0;
   logic [2:0]  fmt_code = 3'd0;
   logic        bclk_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   audio_serial_rx i_audio_serial_rx (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fmt_code(fmt_code),
      .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

   always #(CLK_P/2) clk = ~clk;

   int          total = 0, bad = 0, m_total = 0, m_bad = 0;
   int          wr = 0, npulse = 0;
   logic [23:0] exp_l [256];
   logic [23:0] exp_r [256];
   string       exp_tag [256];
   logic [23:0] prev_word = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Monitor: compares every pulse with the next expected pair
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         m_total += 2;
         if (npulse >= wr) begin
            m_bad++;
            $display("FAIL R8 unexpected pulse actual=%h expected=none", {left_o, right_o});
         end else begin
            if (left_o !== exp_l[npulse]) begin
               m_bad++;
               $display("FAIL %s left actual=%h expected=%h", exp_tag[npulse], left_o, exp_l[npulse]);
            end
            if (right_o !== exp_r[npulse]) begin
               m_bad++;
               $display("FAIL %s right actual=%h expected=%h", exp_tag[npulse], right_o, exp_r[npulse]);
            end
         end
         npulse++;
      end
   end

   function automatic int rj_len(input int f);
      return (f == 0) ? 16 : (f == 1) ? 20 : (f == 4) ? 24 : 0;
   endfunction

   function automatic logic wbit(input int f, input int h, input logic [23:0] w, input int idx);
      int n = rj_len(f);
      if (n != 0) return (idx < h - n) ? logic'(idx % 2 == 0) : w[n - 1 - (idx - (h - n))];
      return (idx < 24) ? w[23 - idx] : logic'(idx % 2 == 1);
   endfunction

   function automatic logic [23:0] exp_word(input int f, input int h, input logic [23:0] v);
      case (f)
         0: return {{8{v[15]}}, v[15:0]};
         1: return {{4{v[19]}}, v[19:0]};
         4: return v;
         default: return (h >= 24) ? v : ((v >> (24 - h)) << (24 - h));
      endcase
   endfunction

   task automatic send_bit(input logic w, input logic d);
      bclk_in = 1'b0; ws_in = w; sd_in = d;
      repeat (BIT_HALF) @(negedge clk);
      bclk_in = 1'b1;
      repeat (BIT_HALF) @(negedge clk);
   endtask

   task automatic send_half(input int f, input int h, input logic w, input logic [23:0] word);
      bit i2s = (f == 3 || f == 6);
      for (int p = 0; p < h; p++) begin
         if (i2s) send_bit(w, (p == 0) ? wbit(f, h, prev_word, h - 1) : wbit(f, h, word, p - 1));
         else     send_bit(w, wbit(f, h, word, p));
      end
      prev_word = word;
   endtask

   task automatic send_frame(input int f, input int h, input logic [23:0] l, input logic [23:0] r);
      logic lw = (f == 3 || f == 6) ? 1'b0 : 1'b1;
      send_half(f, h, lw, l);
      send_half(f, h, ~lw, r);
   endtask

   function automatic string tag_of(input int f);
      case (f)
         0: return "R1 R7 R13";
         1: return "R2 R7 R13";
         2: return "R4 R7 R13";
         3: return "R5 R13";
         4: return "R3 R7 R13";
         default: return "R6 R13";
      endcase
   endfunction

   task automatic run_group(input int f, input int h, input int g, input bit chg);
      int base;
      logic [31:0] mix;
      logic [23:0] l, r;
      pdn_n = 1'b0; fmt_code = 3'(f);
      repeat (4) @(negedge clk);
      pdn_n = 1'b1;
      repeat (4) @(negedge clk);
      base = npulse;
      send_frame(f, h, 24'h5A5A5A, 24'hA5A5A5);
      for (int k = 0; k < 4; k++) begin
         mix = (32'(g) * 32'd7919 + 32'(k) * 32'd104729 + 32'd12345) * 32'h9E3779B1;
         l = mix[31:8]; r = mix[23:0];
         if (k == 0) begin l = 24'h7FFFFF; r = 24'hFF8000; end
         if (k == 1) begin l = 24'h800000; r = 24'h000001; end
         exp_l[wr] = exp_word(f, h, l);
         exp_r[wr] = exp_word(f, h, r);
         exp_tag[wr] = chg ? "R10" : tag_of(f);
         wr++;
         send_frame(f, h, l, r);
         if (chg && k == 1) fmt_code = 3'd4;
      end
      send_frame(f, h, 24'h123456, 24'h654321);
      repeat (30) @(negedge clk);
      chk((npulse - base) == 4 && npulse == wr, chg ? "R10 R8 count" : "R8 count",
          32'(npulse - base), 32'd4);
      pdn_n = 1'b0;
   endtask

   function automatic bit allowed(input int f, input int h);
      case (f)
         0: return 1'b1;
         1: return h >= 20;
         2, 4: return h >= 24;
         3: return h == 16 || h >= 24;
         default: return h == 32;
      endcase
   endfunction

   task automatic run_all;
      int g = 0, base;
      // R12: reset state
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0, "R12 valid", 32'(valid_o), 32'd0);
      chk(left_o == 24'd0, "R12 left", 32'(left_o), 32'd0);
      chk(right_o == 24'd0, "R12 right", 32'(right_o), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0 && left_o == 24'd0, "R12 after release", {8'd0, left_o}, 32'd0);
      for (int f = 0; f < 7; f++) begin
         for (int hi = 0; hi < 4; hi++) begin
            int h = (hi == 0) ? 16 : (hi == 1) ? 20 : (hi == 2) ? 24 : 32;
            if (allowed(f, h)) begin
               run_group(f, h, g, 1'b0);
               g++;
            end
         end
      end
      // R10: change of code while running is ignored
      run_group(0, 32, g, 1'b1);
      // R11: power-down silences the block
      pdn_n = 1'b0; fmt_code = 3'd2;
      base = npulse;
      for (int k = 0; k < 3; k++) send_frame(2, 32, 24'h111111, 24'h222222);
      repeat (30) @(negedge clk);
      chk(npulse == base, "R11 no pulse in power-down", 32'(npulse - base), 32'd0);
      // R9: reserved code yields nothing
      fmt_code = 3'd7;
      repeat (4) @(negedge clk);
      pdn_n = 1'b1;
      base = npulse;
      for (int k = 0; k < 5; k++) send_frame(2, 32, 24'h333333, 24'h444444);
      repeat (30) @(negedge clk);
      chk(npulse == base, "R9 reserved silent", 32'(npulse - base), 32'd0);
      pdn_n = 1'b0;
   endtask

   initial begin
      bit timeout = 1'b0;
      fork
         run_all;
         begin
            repeat (LIMIT) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) begin
         total++; bad++;
         $display("FAIL R8 watchdog actual=hung expected=done");
      end
      total += m_total;
      bad   += m_bad;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule